// File: doc/BRIEF.md
# Two-Phase Addressed Bit Memory

A small single-bit-wide random-access store that holds sixteen bits in a grid of four rows by four columns. The address pins serve both coordinates in turn. On one clock edge an active-low row strobe loads the row coordinate into an internal holding register. On a later edge an active-low column strobe supplies the column coordinate over the same pins. The held row and the column together pick one cell.

A column edge with write enable low stores the data input bit into the selected cell. When the chip is selected, write enable is high and output enable is low, the data output shows the cell picked by the held row and the held column. In every other case the data output stays at 0. A deselected chip ignores every strobe and every write. Reset is synchronous and active low. It clears the storage and both held coordinates.

Top module: `twophase_bitmem`

## Requirements
- R1: A clock edge with `rst_n` low clears all 16 cells, the held row and the held column to 0.
- R2: An edge with `cs_n` and `row_stb_n` both low loads `addr[1:0]` as the held row. The held row is kept unchanged through any number of later edges until the next such edge.
- R3: An edge with `cs_n` and `col_stb_n` both low loads `addr[1:0]` as the held column. It does not change the held row.
- R4: While `cs_n` is high, edges change no cell, no held row and no held column, whatever the strobes, `we_n`, `addr` and `din` are.
- R5: An edge with `cs_n`, `col_stb_n` and `we_n` all low writes `din` into cell (row, column). The row is the held row from before that edge and the column is the `addr[1:0]` on the pins. Cell index = 4*row + column. This also holds when `row_stb_n` is low on the same edge; the new row takes effect only afterwards.
- R6: While `cs_n` is low, `we_n` is high and `oe_n` is low, `dout` combinationally equals cell (held row, held column).
- R7: In every other combination of `cs_n`, `we_n` and `oe_n`, `dout` is 0.
- R8: `addr[3:2]` has no effect on row selection, column selection or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_stb_n | input | 1 | Row coordinate strobe, active low |
| col_stb_n | input | 1 | Column coordinate strobe, active low |
| addr | input | 4 | Shared row/column address pins |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not reading |

## Verification
A row strobe and a column write can land on the same clock edge. Because the pins are shared, the new row value and the write column then come from the same address. The bench provokes this directly. It holds one row, then strobes both phases together with write enable low. It then reads back the cell in the old row, which must carry the new bit, and the cell in the new row, which must be unchanged. The random phase lets both strobes go low together often, and a reference model that applies the write before the row update checks `dout` on every cycle.

// File: rtl/twophase_bitmem_pkg.sv
package twophase_bitmem_pkg;

   // Decoded per-cycle intent, derived from the active-low control pins.
   typedef struct packed {
      logic row_load;
      logic col_load;
      logic cell_write;
      logic read_drive;
   } bm_ctl_t;

   function automatic bm_ctl_t bm_decode(input logic cs_n, input logic we_n,
                                         input logic oe_n, input logic rs_n,
                                         input logic cl_n);
      bm_ctl_t c;
      c.row_load   = ~cs_n & ~rs_n;
      c.col_load   = ~cs_n & ~cl_n;
      c.cell_write = ~cs_n & ~cl_n & ~we_n;
      c.read_drive = ~cs_n &  we_n & ~oe_n;
      return c;
   endfunction

endpackage

// File: rtl/bm_capture.sv
module bm_capture #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

endmodule

// File: rtl/bm_grid.sv
module bm_grid #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int CELLS = ROWS * COLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [ROW_W-1:0] wrow,
   input  logic [COL_W-1:0] wcol,
   input  logic             wbit,
   output logic [CELLS-1:0] cells
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic hit;
         assign hit = wr && (wrow == ROW_W'(r)) && (wcol == COL_W'(c));
         always_ff @(posedge clk) begin
            if (!rst_n)   cells[r*COLS + c] <= 1'b0;
            else if (hit) cells[r*COLS + c] <= wbit;
         end
      end
   end

endmodule

// File: rtl/bm_readout.sv
module bm_readout #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter bit ANDOR_SEL = 1'b0,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int CELLS = ROWS * COLS,
   localparam int IDX_W = $clog2(CELLS)
) (
   input  logic [CELLS-1:0] cells,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic             drive,
   output logic             dout
);

   logic picked;

   if (ANDOR_SEL) begin : g_andor
      logic [CELLS-1:0] hits;
      for (genvar r = 0; r < ROWS; r++) begin : g_r
         for (genvar c = 0; c < COLS; c++) begin : g_c
            assign hits[r*COLS + c] = cells[r*COLS + c] &
                                      (row == ROW_W'(r)) & (col == COL_W'(c));
         end
      end
      assign picked = |hits;
   end else begin : g_index
      logic [IDX_W-1:0] idx;
      assign idx    = IDX_W'(int'(row) * COLS + int'(col));
      assign picked = cells[idx];
   end

   assign dout = drive & picked;

endmodule

// File: rtl/twophase_bitmem.sv
module twophase_bitmem
   import twophase_bitmem_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int ROWS      = 4,
   parameter int COLS      = 4,
   parameter bit ANDOR_SEL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              row_stb_n,
   input  logic              col_stb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              din,
   output logic              dout
);

   localparam int ROW_W = $clog2(ROWS);
   localparam int COL_W = $clog2(COLS);
   localparam int CELLS = ROWS * COLS;

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("twophase_bitmem: ROWS and COLS must each be at least 2");
   end
   if (ROW_W > ADDR_W || COL_W > ADDR_W) begin : g_bad_addr
      $error("twophase_bitmem: ADDR_W too narrow for row or column index");
   end

   bm_ctl_t          ctl;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [CELLS-1:0] cells;

   assign ctl = bm_decode(cs_n, we_n, oe_n, row_stb_n, col_stb_n);

   bm_capture #(.W(ROW_W)) row_hold_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ctl.row_load),
      .d    (addr[ROW_W-1:0]),
      .q    (row_q)
   );

   bm_capture #(.W(COL_W)) col_hold_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ctl.col_load),
      .d    (addr[COL_W-1:0]),
      .q    (col_q)
   );

   bm_grid #(.ROWS(ROWS), .COLS(COLS)) grid_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (ctl.cell_write),
      .wrow (row_q),
      .wcol (addr[COL_W-1:0]),
      .wbit (din),
      .cells(cells)
   );

   bm_readout #(.ROWS(ROWS), .COLS(COLS), .ANDOR_SEL(ANDOR_SEL)) rd_i (
      .cells(cells),
      .row  (row_q),
      .col  (col_q),
      .drive(ctl.read_drive),
      .dout (dout)
   );

endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
   parameter int ADDR_W = 4,
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int CELLS = ROWS * COLS,
   localparam int IDX_W = $clog2(CELLS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              we_n,
   input logic              oe_n,
   input logic              row_stb_n,
   input logic              col_stb_n,
   input logic [ADDR_W-1:0] addr,
   input logic              din,
   input logic              dout,
   input logic [ROW_W-1:0]  row_q,
   input logic [COL_W-1:0]  col_q,
   input logic [CELLS-1:0]  cells
);

   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   assign wr_idx = IDX_W'(int'(row_q) * COLS + int'(addr[COL_W-1:0]));
   assign rd_idx = IDX_W'(int'(row_q) * COLS + int'(col_q));

   // R2: row strobe loads the low address bits
   p_row_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !row_stb_n) |=> row_q == $past(addr[ROW_W-1:0]));

   // R2: row held when not strobed
   p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || row_stb_n) |=> $stable(row_q));

   // R3: column strobe loads the low address bits
   p_col_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !col_stb_n) |=> col_q == $past(addr[COL_W-1:0]));

   // R4: deselected chip changes no state
   p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(cells) && $stable(row_q) && $stable(col_q)));

   // R5: write lands in old-row / pin-column cell
   p_write_cell_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !col_stb_n && !we_n) |=> cells[$past(wr_idx)] == $past(din));

   // R5: reads and idle cycles leave storage unchanged
   p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || col_stb_n || we_n) |=> $stable(cells));

   // R6: read path shows selected cell
   p_read_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && we_n && !oe_n) |-> dout == cells[rd_idx]);

   // R7: output quiet when not reading
   p_dout_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !we_n || oe_n) |-> !dout);

endmodule

bind twophase_bitmem bm_checker #(
   .ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .row_stb_n(row_stb_n),
   .col_stb_n(col_stb_n),
   .addr     (addr),
   .din      (din),
   .dout     (dout),
   .row_q    (row_q),
   .col_q    (col_q),
   .cells    (cells)
);

// File: tb/twophase_bitmem_tb_top.sv
`timescale 1ns/1ps
module twophase_bitmem_tb_top;

   logic       clk = 1'b0;
   logic       rst_n, cs_n, we_n, oe_n, row_stb_n, col_stb_n, din;
   logic [3:0] addr;
   logic       dout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   logic [15:0] m_cells;
   logic [1:0]  m_row, m_col;

   always #10 clk = ~clk;

   twophase_bitmem dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
      .row_stb_n(row_stb_n), .col_stb_n(col_stb_n), .addr(addr),
      .din(din), .dout(dout)
   );

   function automatic logic exp_dout();
      if (!cs_n && we_n && !oe_n) return m_cells[{m_row, m_col}];
      return 1'b0;
   endfunction

   function automatic string auto_tag();
      return (!cs_n && we_n && !oe_n) ? "R6" : "R7";
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_cells = '0; m_row = '0; m_col = '0;
      end else if (!cs_n) begin
         if (!col_stb_n) begin
            if (!we_n) m_cells[{m_row, addr[1:0]}] = din;
            m_col = addr[1:0];
         end
         if (!row_stb_n) m_row = addr[1:0];
      end
   endtask

   // drive one cycle, check dout in the low phase, then advance the model
   task automatic cyc(input logic c, input logic w, input logic o,
                      input logic rs, input logic cl, input logic [3:0] a,
                      input logic d, input string tag);
      @(negedge clk);
      cs_n = c; we_n = w; oe_n = o; row_stb_n = rs; col_stb_n = cl;
      addr = a; din = d;
      #1;
      check((tag == "") ? auto_tag() : tag, dout, exp_dout());
      @(posedge clk);
      model_edge();
   endtask

   task automatic wr(input logic [3:0] r, input logic [3:0] c, input logic d);
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, r, 1'b0, "");
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, c, d, "");
   endtask

   task automatic rd(input logic [3:0] r, input logic [3:0] c, input string tag);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, r, 1'b0, "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, c, 1'b0, "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] pat;
      int unsigned seed;
      seed = 32'd1207;
      void'($urandom(seed));
      pat = 16'hA5C3;
      m_cells = 'x; m_row = 'x; m_col = 'x;
      rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      row_stb_n = 1'b1; col_stb_n = 1'b1; addr = '0; din = 1'b0;
      repeat (3) begin
         @(posedge clk);
         model_edge();
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1: after reset, held row/column 0 and cell 0 reads 0
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 1'b0, "R1");
      rd(4'd3, 4'd2, "R1");

      // R5/R6: fill every cell, read all back
      for (int i = 0; i < 16; i++) wr(4'(i >> 2), 4'(i & 3), pat[i]);
      for (int i = 0; i < 16; i++) rd(4'(i >> 2), 4'(i & 3), "R5");

      // R2: row held across deselected idle cycles
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0, "");
      repeat (3) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0, "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0, "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R2");

      // R3: new column alone moves the selection within the held row
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R3");

      // R4: deselected strobes and write leave cell 4 and the selection intact
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, ~pat[4], "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R4");
      check("R4", dout, pat[4]);

      // R8: upper address bits ignored on row, column and write
      wr(4'b1110, 4'b0101, ~pat[9]);
      rd(4'b0010, 4'b1001, "R8");
      check("R8", dout, ~pat[9]);

      // R5 collision: row strobe and column write on one edge
      wr(4'd3, 4'd0, pat[12]);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, ~pat[13], "");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R2");
      check("R2", dout, pat[5]);
      rd(4'd3, 4'd1, "R5");
      check("R5", dout, ~pat[13]);

      // R7: output quiet with oe_n high, with we_n low, and deselected
      rd(4'd3, 4'd1, "");
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, "R7");
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R7");
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, "R7");

      // random phase, both strobes often together
      for (int k = 0; k < 4000; k++) begin
         logic rc, rw, ro, rrs, rcl;
         rc  = ($urandom_range(0, 9) < 2);
         rw  = ($urandom_range(0, 9) < 6);
         ro  = ($urandom_range(0, 9) < 3);
         rrs = ($urandom_range(0, 9) < 6);
         rcl = ($urandom_range(0, 9) < 5);
         cyc(rc, rw, ro, rrs, rcl, 4'($urandom_range(0, 15)),
             1'($urandom_range(0, 1)), "");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule